// File: doc/BRIEF.md
# ULPI Link-Side Bus Controller

This block is the link end of the 12-pin ULPI bus. It runs on the 60 MHz clock that the PHY supplies. It owns the outgoing data byte and the stop strobe, and it samples the PHY's direction and next-data signals. A small command port lets the surrounding logic ask for three operations: a register write, a register read, or a packet transmit. The block turns each request into a command byte followed by its payload and paces the payload with the PHY's acceptance signal. It closes each outgoing transfer with a one-cycle stop strobe.

When the PHY takes the bus, the controller releases its drivers in the turnaround cycle. It then sorts every later byte into one of three kinds: a status byte, a received packet byte, or the answer to a pending register read. Status and packet bytes come out on a valid/data interface, with a flag that says which kind each byte is. The controller also keeps a receive-active indication. The PHY can start reception either by raising direction and next-data together, or by sending a status byte with the active field set. A command byte that the PHY interrupts by taking the bus is sent again once the bus is free.

Top module: `ulpi_link_ctrl`

## Requirements
- R1: After reset, and whenever the link owns the bus with nothing to send, the data output is 00h, the stop strobe is low, the output enable is high and the command port reports ready.
- R2: A write request (kind 0) drives the command byte {2'b10, address}. After the PHY accepts it with next-data, the write byte is driven. After that byte is accepted, the stop strobe is high for exactly one cycle with data 00h, and in the following cycle the done output pulses.
- R3: A read request (kind 1) drives {2'b11, address}. After acceptance the link drives 00h. The first byte seen with direction high past the turnaround cycle and next-data low is captured on the read-data output with a done pulse, and it is not reported as a status byte.
- R4: A transmit request (kind 2 or 3) drives {2'b01, field}. Payload bytes from the transmit input advance only on cycles where next-data is high, and each advance is marked by a take pulse. After the byte flagged last is accepted, the stop strobe is high for one cycle and done then pulses.
- R5: The output enable drops in the cycle after any edge that samples direction high. After direction falls, it stays low for one further cycle and returns only in the second cycle.
- R6: With direction high past turnaround, next-data low and no read pending, the byte is reported with valid high and the status flag set. This holds back to back and between packet bytes. The turnaround cycle produces no byte.
- R7: With direction high past turnaround and next-data high, the byte is reported with valid high and the status flag clear.
- R8: Receive-active is set when direction and next-data rise together. Each status byte loads receive-active from its bit 4. Receive-active is cleared on any edge that samples direction low.
- R9: If direction rises while a command or its payload is being driven, the link drops to 00h and releases the bus. It keeps the request, and once the bus is free it drives the same command byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-supplied bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ulpi_dir_i | input | 1 | PHY direction: high when the PHY owns the data bus |
| ulpi_nxt_i | input | 1 | PHY next-data / acceptance strobe |
| ulpi_data_i | input | DW | Data bus as seen from the PHY |
| ulpi_data_o | output | DW | Data byte the link drives |
| ulpi_data_oe_o | output | 1 | Link output-enable for the data bus |
| ulpi_stp_o | output | 1 | Stop strobe |
| cmd_valid_i | input | 1 | Request present |
| cmd_ready_o | output | 1 | Request accepted on this cycle if valid |
| cmd_kind_i | input | 2 | 0 write, 1 read, 2 or 3 transmit |
| cmd_addr_i | input | DW-2 | Register address, or transmit command field |
| cmd_wdata_i | input | DW | Register write byte |
| tx_data_i | input | DW | Next transmit payload byte |
| tx_last_i | input | 1 | The presented payload byte is the final one |
| tx_take_o | output | 1 | Pulse: the presented payload byte was latched |
| done_o | output | 1 | Pulse: request finished |
| rd_data_o | output | DW | Byte returned by the last register read |
| rx_valid_o | output | 1 | Received byte is valid this cycle |
| rx_is_cmd_o | output | 1 | Received byte is a status byte (else packet data) |
| rx_data_o | output | DW | Received byte |
| rx_active_o | output | 1 | Receive-active indication |

## Verification
The hardest state to reach is a command byte that the PHY interrupts. To get there, the bench raises direction in the very cycle the command byte first appears. It then slips a status byte in while the request is parked, and checks that the same byte is driven again only once a full turnaround has elapsed. A second hard case is telling a read's answer apart from a status byte. The bench runs register reads over all 64 addresses, with the answer byte placed right after the turnaround, and confirms that no status byte is reported. Receive-active is driven both ways. A packet opens with direction and next-data raised together and carries interleaved and back-to-back status bytes, and a sweep of all 256 status values checks bit 4.

// File: rtl/ulpi_link_pkg.sv
package ulpi_link_pkg;
  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;

  localparam logic [1:0] PFX_SEND  = 2'b01;
  localparam logic [1:0] PFX_WRITE = 2'b10;
  localparam logic [1:0] PFX_READ  = 2'b11;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_DATA,
    SEQ_STOP,
    SEQ_RDWAIT
  } seq_state_e;
endpackage

// File: rtl/ulpi_bus_turn.sv
module ulpi_bus_turn (
  input  logic clk,
  input  logic rst,
  input  logic dir_i,
  output logic bus_free_o,
  output logic turn_o,
  output logic steady_o,
  output logic oe_o
);
  logic dir_q;
  logic oe_q;

  // bus is ours only when direction was low on this and the previous edge
  assign bus_free_o = !dir_i && !dir_q;
  assign turn_o     = dir_i && !dir_q;
  assign steady_o   = dir_i && dir_q;
  assign oe_o       = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      dir_q <= dir_i;
      oe_q  <= bus_free_o;
    end
  end
endmodule

// File: rtl/ulpi_tx_seq.sv
module ulpi_tx_seq
  import ulpi_link_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_free_i,
  input  logic          steady_i,
  input  logic          dir_i,
  input  logic          nxt_i,
  input  logic [DW-1:0] data_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_kind_i,
  input  logic [DW-3:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_last_i,
  output logic          cmd_ready_o,
  output logic [DW-1:0] data_o,
  output logic          stp_o,
  output logic          tx_take_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_wait_o
);
  localparam int AW = DW - 2;

  seq_state_e    state_q;
  logic          pend_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic          stp_q;
  logic          take_q;
  logic          done_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] cmd_byte;

  always_comb begin
    unique case (kind_q)
      KIND_WRITE: cmd_byte = {PFX_WRITE, addr_q};
      KIND_READ:  cmd_byte = {PFX_READ, addr_q};
      default:    cmd_byte = {PFX_SEND, addr_q};
    endcase
  end

  assign cmd_ready_o = (state_q == SEQ_IDLE) && !pend_q;
  assign data_o      = data_q;
  assign stp_o       = stp_q;
  assign tx_take_o   = take_q;
  assign done_o      = done_q;
  assign rd_data_o   = rd_q;
  assign rd_wait_o   = (state_q == SEQ_RDWAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      pend_q  <= 1'b0;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      data_q  <= '0;
      last_q  <= 1'b0;
      stp_q   <= 1'b0;
      take_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= '0;
    end else begin
      stp_q  <= 1'b0;
      take_q <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (!pend_q) begin
            if (cmd_valid_i) begin
              pend_q  <= 1'b1;
              kind_q  <= cmd_kind_i;
              addr_q  <= cmd_addr_i;
              wdata_q <= cmd_wdata_i;
            end
          end else if (bus_free_i) begin
            data_q  <= cmd_byte;
            state_q <= SEQ_CMD;
          end
        end
        SEQ_CMD: begin
          if (dir_i) begin
            // PHY took the bus: park the request and retry later
            data_q  <= '0;
            state_q <= SEQ_IDLE;
          end else if (nxt_i) begin
            unique case (kind_q)
              KIND_READ: begin
                data_q  <= '0;
                state_q <= SEQ_RDWAIT;
              end
              KIND_WRITE: begin
                data_q  <= wdata_q;
                last_q  <= 1'b1;
                state_q <= SEQ_DATA;
              end
              default: begin
                data_q  <= tx_data_i;
                last_q  <= tx_last_i;
                take_q  <= 1'b1;
                state_q <= SEQ_DATA;
              end
            endcase
          end
        end
        SEQ_DATA: begin
          if (dir_i) begin
            data_q  <= '0;
            state_q <= SEQ_IDLE;
          end else if (nxt_i) begin
            if (last_q) begin
              data_q  <= '0;
              stp_q   <= 1'b1;
              state_q <= SEQ_STOP;
            end else begin
              data_q <= tx_data_i;
              last_q <= tx_last_i;
              take_q <= 1'b1;
            end
          end
        end
        SEQ_STOP: begin
          done_q  <= 1'b1;
          pend_q  <= 1'b0;
          state_q <= SEQ_IDLE;
        end
        SEQ_RDWAIT: begin
          if (steady_i && !nxt_i) begin
            rd_q    <= data_i;
            done_q  <= 1'b1;
            pend_q  <= 1'b0;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulpi_rx_sort.sv
module ulpi_rx_sort #(
  parameter int DW       = 8,
  parameter int ACT_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_i,
  input  logic          nxt_i,
  input  logic [DW-1:0] data_i,
  input  logic          turn_i,
  input  logic          steady_i,
  input  logic          rd_wait_i,
  output logic          valid_o,
  output logic          is_cmd_o,
  output logic [DW-1:0] data_o,
  output logic          active_o
);
  logic          valid_q;
  logic          is_cmd_q;
  logic [DW-1:0] data_q;
  logic          active_q;

  assign valid_o  = valid_q;
  assign is_cmd_o = is_cmd_q;
  assign data_o   = data_q;
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      is_cmd_q <= 1'b0;
      data_q   <= '0;
      active_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!dir_i) begin
        active_q <= 1'b0;
      end else if (turn_i) begin
        if (nxt_i) active_q <= 1'b1;
      end else if (steady_i) begin
        if (nxt_i) begin
          valid_q  <= 1'b1;
          is_cmd_q <= 1'b0;
          data_q   <= data_i;
        end else if (!rd_wait_i) begin
          valid_q  <= 1'b1;
          is_cmd_q <= 1'b1;
          data_q   <= data_i;
          active_q <= data_i[ACT_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/ulpi_link_ctrl.sv
module ulpi_link_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ulpi_dir_i,
  input  logic          ulpi_nxt_i,
  input  logic [DW-1:0] ulpi_data_i,
  output logic [DW-1:0] ulpi_data_o,
  output logic          ulpi_data_oe_o,
  output logic          ulpi_stp_o,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_kind_i,
  input  logic [DW-3:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_last_i,
  output logic          tx_take_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rx_valid_o,
  output logic          rx_is_cmd_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_active_o
);
  localparam int ACT_BIT = 4;

  logic bus_free;
  logic turn;
  logic steady;
  logic rd_wait;

  ulpi_bus_turn i_turn (
    .clk        (clk),
    .rst        (rst),
    .dir_i      (ulpi_dir_i),
    .bus_free_o (bus_free),
    .turn_o     (turn),
    .steady_o   (steady),
    .oe_o       (ulpi_data_oe_o)
  );

  ulpi_tx_seq #(.DW(DW)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .bus_free_i  (bus_free),
    .steady_i    (steady),
    .dir_i       (ulpi_dir_i),
    .nxt_i       (ulpi_nxt_i),
    .data_i      (ulpi_data_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_kind_i  (cmd_kind_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .tx_data_i   (tx_data_i),
    .tx_last_i   (tx_last_i),
    .cmd_ready_o (cmd_ready_o),
    .data_o      (ulpi_data_o),
    .stp_o       (ulpi_stp_o),
    .tx_take_o   (tx_take_o),
    .done_o      (done_o),
    .rd_data_o   (rd_data_o),
    .rd_wait_o   (rd_wait)
  );

  ulpi_rx_sort #(.DW(DW), .ACT_BIT(ACT_BIT)) i_rx (
    .clk       (clk),
    .rst       (rst),
    .dir_i     (ulpi_dir_i),
    .nxt_i     (ulpi_nxt_i),
    .data_i    (ulpi_data_i),
    .turn_i    (turn),
    .steady_i  (steady),
    .rd_wait_i (rd_wait),
    .valid_o   (rx_valid_o),
    .is_cmd_o  (rx_is_cmd_o),
    .data_o    (rx_data_o),
    .active_o  (rx_active_o)
  );
endmodule

// File: rtl/ulpi_link_chk.sv
module ulpi_link_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ulpi_dir_i,
  input logic          ulpi_nxt_i,
  input logic [DW-1:0] ulpi_data_o,
  input logic          ulpi_data_oe_o,
  input logic          ulpi_stp_o,
  input logic          tx_take_o,
  input logic          done_o,
  input logic          rx_valid_o,
  input logic          rx_active_o
);
  a_r2_stp_single: assert property (@(posedge clk) disable iff (rst)
    ulpi_stp_o |=> !ulpi_stp_o);

  a_r2_stp_data_zero: assert property (@(posedge clk) disable iff (rst)
    ulpi_stp_o |-> (ulpi_data_o == '0));

  a_r5_release_on_dir: assert property (@(posedge clk) disable iff (rst)
    ulpi_dir_i |=> !ulpi_data_oe_o);

  a_r5_late_reenable: assert property (@(posedge clk) disable iff (rst)
    $fell(ulpi_dir_i) |=> !ulpi_data_oe_o);

  a_r1_undriven_zero: assert property (@(posedge clk) disable iff (rst)
    !ulpi_data_oe_o |-> (ulpi_data_o == '0));

  a_r6_rx_after_dir: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(ulpi_dir_i));

  a_r8_active_after_dir: assert property (@(posedge clk) disable iff (rst)
    rx_active_o |-> $past(ulpi_dir_i));

  a_r4_take_after_nxt: assert property (@(posedge clk) disable iff (rst)
    tx_take_o |-> $past(ulpi_nxt_i));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind ulpi_link_ctrl ulpi_link_chk #(.DW(DW)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .ulpi_dir_i     (ulpi_dir_i),
  .ulpi_nxt_i     (ulpi_nxt_i),
  .ulpi_data_o    (ulpi_data_o),
  .ulpi_data_oe_o (ulpi_data_oe_o),
  .ulpi_stp_o     (ulpi_stp_o),
  .tx_take_o      (tx_take_o),
  .done_o         (done_o),
  .rx_valid_o     (rx_valid_o),
  .rx_active_o    (rx_active_o)
);

// File: tb/test_ulpi_link_ctrl.sv
module test_ulpi_link_ctrl;
  localparam int DW = 8;
  localparam int AW = DW - 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          dir, nxt;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          oe, stp;
  logic          cmd_valid, cmd_ready;
  logic [1:0]    cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [DW-1:0] tx_data;
  logic          tx_last, tx_take, done;
  logic [DW-1:0] rd_data;
  logic          rx_valid, rx_is_cmd, rx_active;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ulpi_link_ctrl #(.DW(DW)) i_ulpi_link_ctrl (
    .clk(clk), .rst(rst),
    .ulpi_dir_i(dir), .ulpi_nxt_i(nxt), .ulpi_data_i(din),
    .ulpi_data_o(dout), .ulpi_data_oe_o(oe), .ulpi_stp_o(stp),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_kind_i(cmd_kind),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .tx_data_i(tx_data), .tx_last_i(tx_last), .tx_take_o(tx_take),
    .done_o(done), .rd_data_o(rd_data),
    .rx_valid_o(rx_valid), .rx_is_cmd_o(rx_is_cmd), .rx_data_o(rx_data),
    .rx_active_o(rx_active)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tk();
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pay(input int field, input int k);
    return DW'(8'h30 + field + k * 7);
  endfunction

  // present a request; returns at the negedge after the command byte is launched
  task automatic issue(input logic [1:0] kind, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
    chk("R1", "ready before request", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_addr = a; cmd_wdata = wd;
    tk();
    cmd_valid = 1'b0;
    tk();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] wd);
    issue(2'd0, a, wd);
    chk("R2", "write command byte", dout, {2'b10, a});
    chk("R2", "write oe", oe, 1);
    nxt = 1'b1;
    tk();
    chk("R2", "write data byte", dout, wd);
    tk();
    chk("R2", "stop high", stp, 1);
    chk("R2", "stop data zero", dout, 0);
    nxt = 1'b0;
    tk();
    chk("R2", "stop single cycle", stp, 0);
    chk("R2", "write done", done, 1);
    tk();
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] rv);
    issue(2'd1, a, 0);
    chk("R3", "read command byte", dout, {2'b11, a});
    nxt = 1'b1;
    tk();
    chk("R3", "idle byte after read accept", dout, 0);
    nxt = 1'b0; dir = 1'b1;
    tk();
    chk("R5", "release after dir rise", oe, 0);
    chk("R6", "no byte in turnaround", rx_valid, 0);
    din = rv;
    tk();
    chk("R3", "read done", done, 1);
    chk("R3", "read data", rd_data, rv);
    chk("R3", "read byte not status", rx_valid, 0);
    dir = 1'b0; din = '0;
    tk();
    chk("R5", "still released after dir fall", oe, 0);
    tk();
    chk("R5", "reenabled second cycle", oe, 1);
  endtask

  task automatic do_tx(input logic [AW-1:0] field, input int n);
    int takes = 0;
    tx_data = pay(field, 0);
    tx_last = (n == 1);
    issue(2'd2, field, 0);
    chk("R4", "transmit command byte", dout, {2'b01, field});
    nxt = 1'b1;
    for (int k = 0; k < n; k++) begin
      tk();
      if (tx_take) takes++;
      chk("R4", "payload byte", dout, pay(field, k));
      tx_data = pay(field, k + 1);
      tx_last = (k + 1 == n - 1);
      nxt = 1'b0;
      tk();
      chk("R4", "payload holds without nxt", dout, pay(field, k));
      nxt = 1'b1;
    end
    tk();
    chk("R4", "stop after last", stp, 1);
    chk("R4", "take pulses", takes, n);
    nxt = 1'b0;
    tk();
    chk("R4", "transmit done", done, 1);
    tk();
  endtask

  task automatic rx_status(input logic [DW-1:0] v);
    dir = 1'b1; nxt = 1'b0;
    tk();
    chk("R6", "turnaround silent", rx_valid, 0);
    din = v;
    tk();
    chk("R6", "status valid", rx_valid, 1);
    chk("R6", "status flag", rx_is_cmd, 1);
    chk("R6", "status data", rx_data, v);
    chk("R8", "active from bit 4", rx_active, v[4]);
    dir = 1'b0; din = '0;
    tk();
    chk("R8", "active cleared by dir low", rx_active, 0);
    tk();
  endtask

  initial begin
    rst = 1'b1; dir = 1'b0; nxt = 1'b0; din = '0;
    cmd_valid = 1'b0; cmd_kind = '0; cmd_addr = '0; cmd_wdata = '0;
    tx_data = '0; tx_last = 1'b0;
    repeat (3) tk();
    rst = 1'b0;
    tk(); tk();
    chk("R1", "reset data", dout, 0);
    chk("R1", "reset stop", stp, 0);
    chk("R1", "reset oe", oe, 1);
    chk("R1", "reset ready", cmd_ready, 1);
    chk("R8", "reset active", rx_active, 0);

    for (int a = 0; a < 64; a++) do_write(AW'(a), DW'(a * 3 + 1));
    for (int a = 0; a < 64; a++) do_read(AW'(a), DW'(a ^ 8'h5A));
    for (int n = 1; n <= 4; n++) do_tx(AW'(n * 5), n);
    for (int v = 0; v < 256; v++) rx_status(DW'(v));

    // packet: dir and nxt together, interleaved and back-to-back status bytes
    dir = 1'b1; nxt = 1'b1;
    tk();
    chk("R8", "active from dir with nxt", rx_active, 1);
    chk("R6", "turnaround silent in packet", rx_valid, 0);
    din = 8'hA1;
    tk();
    chk("R7", "packet valid", rx_valid, 1);
    chk("R7", "packet flag", rx_is_cmd, 0);
    chk("R7", "packet data", rx_data, 8'hA1);
    din = 8'h15; nxt = 1'b0;
    tk();
    chk("R6", "mid-packet status flag", rx_is_cmd, 1);
    chk("R6", "mid-packet status data", rx_data, 8'h15);
    chk("R8", "active held", rx_active, 1);
    din = 8'h14;
    tk();
    chk("R6", "back-to-back status", rx_data, 8'h14);
    chk("R6", "back-to-back valid", rx_valid, 1);
    din = 8'hA2; nxt = 1'b1;
    tk();
    chk("R7", "second packet byte", rx_data, 8'hA2);
    chk("R7", "second packet flag", rx_is_cmd, 0);
    din = 8'h20; nxt = 1'b0;
    tk();
    chk("R8", "active cleared by status", rx_active, 0);
    dir = 1'b0; din = '0;
    tk(); tk();

    // interrupted command byte is retried
    issue(2'd0, 6'h2A, 8'h77);
    chk("R9", "first attempt byte", dout, 8'hAA);
    dir = 1'b1;
    tk();
    chk("R9", "released on takeover", oe, 0);
    chk("R9", "data dropped", dout, 0);
    chk("R9", "request kept", cmd_ready, 0);
    din = 8'h01;
    tk();
    chk("R6", "status during park", rx_valid, 1);
    dir = 1'b0; din = '0;
    tk();
    chk("R9", "no retry during turnaround", dout, 0);
    tk();
    chk("R9", "retry byte", dout, 8'hAA);
    chk("R9", "retry oe", oe, 1);
    nxt = 1'b1;
    tk();
    chk("R9", "retry data", dout, 8'h77);
    tk();
    chk("R9", "retry stop", stp, 1);
    nxt = 1'b0;
    tk();
    chk("R9", "retry done", done, 1);
    tk();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule